// File: doc/BRIEF.md
# Three-Mode Interval Timer

This block is a single programmable interval timer built around one W-bit counter (32 bits by default) and one bidirectional pin. The counter serves three mutually exclusive modes. In pulse-generation mode the block drives a pulse-width-modulated waveform whose period and high time come from two registers. In width-capture mode it measures the incoming signal's period and high time in clock cycles. In event-count mode it counts rising edges on the pin and flags an event each time the count reaches a limit.

The selected mode also sets the pin direction: the pin is driven only in pulse-generation mode while the timer is enabled. The pin input passes through a synchronizer whose depth is a parameter. Every mode sets a sticky interrupt flag, and software clears it by writing a one. Registers are written through a small write port. Their contents are visible on dedicated read outputs.

Top module: `gpt_timer`

## Requirements
- R1: After reset the count, period and width outputs are zero, status is 2'b00, irq is low, and pin_oe is low.
- R2: Write port addresses: 0 is config (bit 0 enable, bits 2:1 mode, where 0 is pulse, 1 is capture, 2 is event, and 3 holds the counter), 1 is period, 2 is width, 3 is the counter, and 4 is status. A counter write overrides the counter value in that cycle.
- R3: Writing config with enable set while the timer is disabled loads the counter with 1 in pulse mode and with 0 in the other modes.
- R4: In pulse mode the counter steps from 1 to the period value and then returns to 1. At the end of each period it sets status bit 0.
- R5: In pulse mode, pin_oe is high and pin_o is high exactly when the counter is less than or equal to the width value. A width of 0 keeps pin_o low.
- R6: In capture mode each synchronized rising edge of pin_i stores the count into period and restarts the count, so the stored value equals the rising-to-rising interval in clock cycles. Each period capture sets status bit 0.
- R7: In capture mode each synchronized falling edge stores the count into width. The stored value equals the high time in clock cycles.
- R8: In capture mode, if the counter passes its all-ones value without a rising edge, the counter wraps and status bit 1 (overflow) and status bit 0 are both set.
- R9: In event mode the counter advances by one on each synchronized rising edge of pin_i. When the new count reaches the period value, the counter returns to 0 and status bit 0 is set.
- R10: While disabled, the counter holds its value and pin_oe and pin_o are low. pin_oe is also low in capture and event modes.
- R11: Status bits are sticky, and writing a one to a status bit clears it. If a set and a clear hit the same bit in the same cycle, the bit stays set. irq follows status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| pin_i | input | 1 | Pin input value |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| count_o | output | W | Current counter |
| period_o | output | W | Period register |
| width_o | output | W | Width register |
| status_o | output | 2 | Status: bit 0 interrupt, bit 1 overflow |
| irq | output | 1 | Interrupt request |

## Verification
Reaching the capture-mode overflow from the ports is the hardest case, because a free-running 32-bit count would need billions of idle cycles before it wrapped. The stimulus enables capture mode with the pin held low, then writes the counter to a few steps below all-ones, so the wrap comes within a handful of cycles. The same pass also checks the write-one-to-clear behaviour on each status bit separately. Pulse and capture timing use random periods and widths from a fixed seed, compared against a cycle model in the bench.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   typedef enum logic [1:0] {
      GPT_PULSE = 2'd0,
      GPT_CAPT  = 2'd1,
      GPT_EVENT = 2'd2,
      GPT_IDLE  = 2'd3
   } gpt_mode_e;

   localparam logic [2:0] GPT_A_CFG    = 3'd0;
   localparam logic [2:0] GPT_A_PERIOD = 3'd1;
   localparam logic [2:0] GPT_A_WIDTH  = 3'd2;
   localparam logic [2:0] GPT_A_COUNT  = 3'd3;
   localparam logic [2:0] GPT_A_STATUS = 3'd4;
endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpt_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= d;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else last <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last;
   assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/gpt_core.sv
module gpt_core
   import gpt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  gpt_mode_e    mode,
   input  logic         start,
   input  gpt_mode_e    start_mode,
   input  logic         rise,
   input  logic         fall,
   input  logic [W-1:0] period,
   input  logic [W-1:0] width,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_wdata,
   output logic [W-1:0] count,
   output logic         pulse_high,
   output logic         cap_per,
   output logic         cap_wid,
   output logic         term,
   output logic         ovf
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] nxt;
   logic [W:0]   inc_wide;

   assign inc_wide = {1'b0, count} + {{W{1'b0}}, 1'b1};

   always_comb begin
      nxt     = count;
      term    = 1'b0;
      ovf     = 1'b0;
      cap_per = 1'b0;
      cap_wid = 1'b0;
      if (start) begin
         nxt = (start_mode == GPT_PULSE) ? CNT_ONE : '0;
      end else if (en) begin
         case (mode)
            GPT_PULSE: begin
               if (count >= period) begin
                  nxt  = CNT_ONE;
                  term = 1'b1;
               end else begin
                  nxt = inc_wide[W-1:0];
               end
            end
            GPT_CAPT: begin
               cap_wid = fall;
               if (rise) begin
                  cap_per = 1'b1;
                  nxt     = CNT_ONE;
               end else begin
                  nxt = inc_wide[W-1:0];
                  ovf = (count == CNT_MAX);
               end
            end
            GPT_EVENT: begin
               if (rise) begin
                  if (inc_wide >= {1'b0, period}) begin
                     nxt  = '0;
                     term = 1'b1;
                  end else begin
                     nxt = inc_wide[W-1:0];
                  end
               end
            end
            default: nxt = count;
         endcase
      end
      if (cnt_wr) nxt = cnt_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else count <= nxt;
   end

   assign pulse_high = en && (mode == GPT_PULSE) && (count <= width);
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         pin_i,
   output logic         pin_o,
   output logic         pin_oe,
   output logic [W-1:0] count_o,
   output logic [W-1:0] period_o,
   output logic [W-1:0] width_o,
   output logic [1:0]   status_o,
   output logic         irq
);
   generate
      if (W < 8) begin : g_bad_w
         $error("gpt_timer: W must be at least 8");
      end
   endgenerate

   logic         en_q;
   gpt_mode_e    mode_q;
   logic [W-1:0] period_q, width_q;
   logic [1:0]   st_q;
   logic         rise, fall, start;
   logic         pulse_high, cap_per, cap_wid, term, ovf;
   logic         wr_cfg, wr_per, wr_wid, wr_cnt, wr_st;
   gpt_mode_e    wmode;

   assign wr_cfg = wr_en && (wr_addr == GPT_A_CFG);
   assign wr_per = wr_en && (wr_addr == GPT_A_PERIOD);
   assign wr_wid = wr_en && (wr_addr == GPT_A_WIDTH);
   assign wr_cnt = wr_en && (wr_addr == GPT_A_COUNT);
   assign wr_st  = wr_en && (wr_addr == GPT_A_STATUS);
   assign wmode  = gpt_mode_e'(wr_data[2:1]);
   assign start  = wr_cfg && wr_data[0] && !en_q;

   gpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .rise(rise), .fall(fall)
   );

   gpt_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q),
      .start(start), .start_mode(wmode), .rise(rise), .fall(fall),
      .period(period_q), .width(width_q), .cnt_wr(wr_cnt),
      .cnt_wdata(wr_data), .count(count_o), .pulse_high(pulse_high),
      .cap_per(cap_per), .cap_wid(cap_wid), .term(term), .ovf(ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         mode_q   <= GPT_PULSE;
         period_q <= '0;
         width_q  <= '0;
         st_q     <= 2'b00;
      end else begin
         if (wr_cfg) begin
            en_q   <= wr_data[0];
            mode_q <= wmode;
         end
         if (wr_per) period_q <= wr_data;
         else if (cap_per) period_q <= count_o;
         if (wr_wid) width_q <= wr_data;
         else if (cap_wid) width_q <= count_o;
         st_q[0] <= (term | cap_per | ovf) | (st_q[0] & ~(wr_st & wr_data[0]));
         st_q[1] <= ovf | (st_q[1] & ~(wr_st & wr_data[1]));
      end
   end

   assign pin_oe   = en_q && (mode_q == GPT_PULSE);
   assign pin_o    = pulse_high;
   assign period_o = period_q;
   assign width_o  = width_q;
   assign status_o = st_q;
   assign irq      = st_q[0];
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic [1:0]   mode,
   input logic         wr_en,
   input logic [2:0]   wr_addr,
   input logic [W-1:0] count,
   input logic [W-1:0] period,
   input logic         pin_o,
   input logic         pin_oe,
   input logic         irq,
   input logic         ovf
);
   AST_PULSE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == 2'd0 && !wr_en && count >= period) |=> (count == {{(W-1){1'b0}}, 1'b1})); // R4
   AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || mode != 2'd0) |-> !pin_oe); // R10
   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_o); // R10
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_en) |=> $stable(count)); // R10
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && wr_addr == 3'd4)) |=> irq); // R11
   AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> irq); // R8
endmodule

bind gpt_timer gpt_timer_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .wr_en(wr_en),
   .wr_addr(wr_addr), .count(count_o), .period(period_q), .pin_o(pin_o),
   .pin_oe(pin_oe), .irq(irq), .ovf(status_o[1])
);

// File: tb/tb_gpt_timer.sv
module tb_gpt_timer;
   localparam int W = 32;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         pin_i = 1'b0;
   logic         pin_o, pin_oe, irq;
   logic [W-1:0] count_o, period_o, width_o;
   logic [1:0]   status_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpt_timer #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
      .count_o(count_o), .period_o(period_o), .width_o(width_o),
      .status_o(status_o), .irq(irq)
   );

   function automatic logic exp_pin(int unsigned c, int unsigned w);
      return c <= w;
   endfunction

   function automatic int unsigned exp_next(int unsigned c, int unsigned p);
      return (c >= p) ? 1 : c + 1;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(count_o == 0 && period_o == 0 && width_o == 0, "R1", count_o, 0);
      check(status_o == 2'b00 && !irq && !pin_oe, "R1", status_o, 0);
      rst_n = 1'b1;
      idle(2);

      // R4 R5 R3 pulse mode, random plus corners (width 0, width > period)
      for (int t = 0; t < 8; t++) begin
         int unsigned p, w, c;
         int bad_pin, bad_cnt;
         p = 2 + $urandom_range(0, 18);
         w = (t == 0) ? 0 : (t == 1) ? p + 1 : $urandom_range(1, p);
         wr(3'd0, 0);
         wr(3'd1, p);
         wr(3'd2, w);
         wr(3'd4, 3);
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h1;
         @(negedge clk);
         wr_en = 1'b0;
         c = 1;
         check(count_o == 1, "R3", count_o, 1);
         bad_pin = 0; bad_cnt = 0;
         for (int k = 0; k < 3 * p; k++) begin
            if (pin_o !== exp_pin(c, w) || !pin_oe) bad_pin++;
            if (count_o != c) bad_cnt++;
            c = exp_next(c, p);
            @(negedge clk);
         end
         check(bad_pin == 0, "R5", bad_pin, 0);
         check(bad_cnt == 0, "R4", bad_cnt, 0);
         check(irq == 1'b1, "R4", irq, 1);
      end

      // R10 disable holds counter and releases pin
      begin
         logic [W-1:0] held;
         wr(3'd0, 0);
         held = count_o;
         idle(6);
         check(count_o == held, "R10", count_o, held);
         check(!pin_oe && !pin_o, "R10", pin_oe, 0);
      end

      // R6 R7 capture, random intervals
      for (int t = 0; t < 6; t++) begin
         int unsigned p, h;
         p = $urandom_range(4, 30);
         h = $urandom_range(1, p - 1);
         wr(3'd0, 0);
         wr(3'd4, 3);
         wr(3'd0, 32'h3);
         check(!pin_oe, "R10", pin_oe, 0);
         for (int r = 0; r < 3; r++) begin
            @(negedge clk); pin_i = 1'b1;
            repeat (h) @(negedge clk);
            pin_i = 1'b0;
            repeat (p - h - 1) @(negedge clk);
         end
         idle(2);
         check(period_o == p, "R6", period_o, p);
         check(width_o == h, "R7", width_o, h);
         check(irq == 1'b1, "R6", irq, 1);
      end

      // R8 overflow, preloaded counter, pin static low
      wr(3'd0, 0);
      wr(3'd4, 3);
      wr(3'd0, 32'h3);
      idle(4);
      wr(3'd3, 32'hFFFF_FFFC);
      idle(10);
      check(status_o == 2'b11, "R8", status_o, 3);
      check(count_o < 32'd20, "R8", count_o, 10);
      // R11 write-one-to-clear, per bit
      wr(3'd4, 2);
      check(status_o == 2'b01, "R11", status_o, 1);
      wr(3'd4, 1);
      check(status_o == 2'b00 && !irq, "R11", status_o, 0);

      // R9 event counting
      for (int t = 0; t < 3; t++) begin
         int unsigned n;
         n = $urandom_range(2, 7);
         wr(3'd0, 0);
         wr(3'd1, n);
         wr(3'd4, 3);
         wr(3'd0, 32'h5);
         for (int e = 0; e < n - 1; e++) begin
            pin_i = 1'b1; idle(3);
            pin_i = 1'b0; idle(3);
         end
         idle(5);
         check(count_o == n - 1, "R9", count_o, n - 1);
         check(!irq, "R9", irq, 0);
         pin_i = 1'b1; idle(3);
         pin_i = 1'b0; idle(6);
         check(count_o == 0, "R9", count_o, 0);
         check(irq == 1'b1, "R9", irq, 1);
      end

      // R2 counter write overrides; mode 3 holds counter
      wr(3'd0, 0);
      wr(3'd0, 32'h7);
      wr(3'd3, 32'd1234);
      idle(4);
      check(count_o == 1234, "R2", count_o, 1234);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule